// File: doc/BRIEF.md
# Serial EEPROM Status Register and Write Guard

This block keeps the status byte of a serial EEPROM and rules on every write the device is asked to make. It holds the write-enable latch, the two block-lock bits and the lock-pin enable bit, and it reports a read-only busy flag. The command decoder gives it a one-cycle strobe for each completed enable, disable or status-write opcode. The write-cycle timer gives it a busy level and a completion strobe. The pin side gives it the chip-select level, the active-low write-protect pin and the address of the array byte that is about to be written.

The block returns the live status byte for status reads. It also returns two grant flags, one for array writes at the given address and one for status writes, and a one-cycle launch strobe when a status write is committed at the end of its frame. All state resets to zero, which stands in for the power-up state. A frame ends on the first clock edge at which chip select is sampled high after having been low. That edge is where enable, disable and status writes take effect.

Top module: `sguard_top`

## Requirements
- R1: The status byte is {lock-pin enable, 3'b000, lock1, lock0, write-enable latch, busy} with bit 7 first. After reset all of it reads 0 and both grant flags are 0.
- R2: Bit 0 of the status byte equals the busy input in the same cycle.
- R3: An enable strobe sets the latch (bit 1) only at the end of its frame. While that frame is still open the latch reads 0 and no write is granted.
- R4: A disable strobe clears the latch at the end of its frame. Before that edge the latch still reads 1.
- R5: An array write at address A is granted only when the latch is 1, busy is 0 and A lies outside the locked range. For an address width of 14, lock code {bit3,bit2} = 00 locks nothing, 01 locks 0x3000..0x3FFF, 10 locks 0x2000..0x3FFF and 11 locks every address.
- R6: A status write is granted only when the latch is 1, busy is 0, and the pin lock is not in force. The pin lock is in force when the write-protect pin is low and bit 7 is 1.
- R7: A granted status write changes only bits 7, 3 and 2, each taking the value of the same bit of the written byte. The change happens at the end of its frame, in the cycle where the launch strobe is 1.
- R8: If the pin lock comes into force while chip select is still low after a status write was accepted, that write is dropped: no launch strobe and no change to any bit. A pin change after the launch has no effect on the stored bits.
- R9: A completion strobe from the write-cycle timer clears the latch on the next edge.
- R10: While busy is 1, enable, disable and status-write strobes are ignored, and the latch and stored bits keep their values.
- R11: A status-write strobe while the latch is 0 is refused: no launch and no bit change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, stands in for power-up |
| cs_n | input | 1 | Chip select level, low while a frame is open |
| wren_hit | input | 1 | Strobe: enable opcode fully received |
| wrdi_hit | input | 1 | Strobe: disable opcode fully received |
| wrsr_hit | input | 1 | Strobe: status-write data byte fully received |
| wrsr_byte | input | 8 | Data byte of the status write |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Write-cycle timer is running |
| wr_done | input | 1 | Strobe: a byte, page or status write cycle has finished |
| wr_addr | input | ADDR_W | Target address of the pending array write |
| status | output | 8 | Live status byte |
| arr_wr_ok | output | 1 | Array write at wr_addr is allowed |
| sr_wr_ok | output | 1 | Status write is allowed now |
| sr_launch | output | 1 | Status write committed this cycle, starts the timer |

## Verification
The bench sets every lock code and both values of the enable bit. Under each one it walks the latch, pin and busy combinations over addresses spread across the whole space, and computes the locked range by comparing the address with a floor. A design whose range decode is off by a quarter, or that leaves out busy or the latch, fails there. Separate cases check that a write in the same frame as its enable is refused, that a disable takes effect only at frame end, and that a status write is dropped when the pin falls mid-frame but keeps its bits when the pin falls after launch. They also check that the masked bits 6..4 and 1..0 of the written byte never land in the register.

// File: rtl/sguard_pkg.sv
package sguard_pkg;

  localparam int SR_LOCKEN = 7;
  localparam int SR_LK1    = 3;
  localparam int SR_LK0    = 2;
  localparam int SR_WEL    = 1;
  localparam int SR_BUSY   = 0;

  typedef struct packed {
    logic       locken;
    logic [1:0] lk;
  } sg_nv_t;

  // Lowest locked address for a lock code; code 0 means nothing locked.
  function automatic logic [31:0] lock_floor(input logic [1:0] lk, input int aw);
    logic [31:0] q;
    q = 32'd1 << (aw - 2);
    case (lk)
      2'b01:   return 32'd3 * q;
      2'b10:   return 32'd2 * q;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic addr_locked(input logic [31:0] a, input logic [1:0] lk, input int aw);
    return (lk != 2'b00) && (a >= lock_floor(lk, aw));
  endfunction

  function automatic sg_nv_t nv_from_byte(input logic [7:0] d);
    sg_nv_t n;
    n.locken = d[SR_LOCKEN];
    n.lk     = {d[SR_LK1], d[SR_LK0]};
    return n;
  endfunction

  function automatic logic [7:0] pack_status(input sg_nv_t n, input logic wel, input logic bsy);
    logic [7:0] s;
    s = 8'h00;
    s[SR_LOCKEN] = n.locken;
    s[SR_LK1]    = n.lk[1];
    s[SR_LK0]    = n.lk[0];
    s[SR_WEL]    = wel;
    s[SR_BUSY]   = bsy;
    return s;
  endfunction

endpackage

// File: rtl/sguard_wel.sv
module sguard_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic frame_end,
  input  logic busy,
  input  logic set_req,
  input  logic clr_req,
  input  logic done,
  output logic wel
);

  logic set_p;
  logic clr_p;
  logic live;

  assign live = ~cs_n & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel   <= 1'b0;
      set_p <= 1'b0;
      clr_p <= 1'b0;
    end else begin
      if (done) begin
        wel <= 1'b0;
      end else if (frame_end && !busy) begin
        if (clr_p)      wel <= 1'b0;
        else if (set_p) wel <= 1'b1;
      end
      if (cs_n) begin
        set_p <= 1'b0;
        clr_p <= 1'b0;
      end else if (live) begin
        if (set_req) set_p <= 1'b1;
        if (clr_req) clr_p <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sguard_nvbits.sv
module sguard_nvbits
  import sguard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       frame_end,
  input  logic       busy,
  input  logic       wrsr_req,
  input  logic [7:0] wrsr_byte,
  input  logic       grant,
  input  logic       hw_lock,
  output sg_nv_t     nv,
  output logic       launch,
  output logic       abort
);

  logic   pend;
  sg_nv_t pdata;

  assign abort  = pend & hw_lock & ~cs_n;
  assign launch = frame_end & pend & ~hw_lock & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      pdata <= '0;
      nv    <= '0;
    end else begin
      if (cs_n) begin
        pend <= 1'b0;
      end else if (abort) begin
        pend <= 1'b0;
      end else if (wrsr_req && grant) begin
        pend  <= 1'b1;
        pdata <= nv_from_byte(wrsr_byte);
      end
      if (launch) nv <= pdata;
    end
  end

endmodule

// File: rtl/sguard_decide.sv
module sguard_decide
  import sguard_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              wel,
  input  logic              busy,
  input  sg_nv_t            nv,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              arr_ok,
  output logic              sr_ok,
  output logic              hw_lock
);

  localparam int PAD = 32 - ADDR_W;

  logic [31:0] addr_w;
  logic        in_lock;

  generate
    if (PAD > 0) begin : g_pad
      assign addr_w = {{PAD{1'b0}}, addr};
    end else begin : g_nopad
      assign addr_w = addr;
    end
  endgenerate

  assign in_lock = addr_locked(addr_w, nv.lk, ADDR_W);
  assign hw_lock = ~wp_n & nv.locken;
  assign arr_ok  = wel & ~busy & ~in_lock;
  assign sr_ok   = wel & ~busy & ~hw_lock;

endmodule

// File: rtl/sguard_top.sv
module sguard_top
  import sguard_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wren_hit,
  input  logic              wrdi_hit,
  input  logic              wrsr_hit,
  input  logic [7:0]        wrsr_byte,
  input  logic              wp_n,
  input  logic              busy,
  input  logic              wr_done,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        status,
  output logic              arr_wr_ok,
  output logic              sr_wr_ok,
  output logic              sr_launch
);

  logic   cs_q;
  logic   frame_end;
  logic   wel;
  logic   hw_lock;
  logic   sr_abort;
  sg_nv_t nv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_n;
  end

  assign frame_end = cs_n & ~cs_q;

  sguard_wel u_wel (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .frame_end(frame_end),
    .busy     (busy),
    .set_req  (wren_hit),
    .clr_req  (wrdi_hit),
    .done     (wr_done),
    .wel      (wel)
  );

  sguard_decide #(.ADDR_W(ADDR_W)) u_dec (
    .wel    (wel),
    .busy   (busy),
    .nv     (nv),
    .wp_n   (wp_n),
    .addr   (wr_addr),
    .arr_ok (arr_wr_ok),
    .sr_ok  (sr_wr_ok),
    .hw_lock(hw_lock)
  );

  sguard_nvbits u_nv (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .frame_end(frame_end),
    .busy     (busy),
    .wrsr_req (wrsr_hit),
    .wrsr_byte(wrsr_byte),
    .grant    (sr_wr_ok),
    .hw_lock  (hw_lock),
    .nv       (nv),
    .launch   (sr_launch),
    .abort    (sr_abort)
  );

  assign status = pack_status(nv, wel, busy);

endmodule

// File: rtl/sguard_chk.sv
module sguard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       wp_n,
  input logic       busy,
  input logic       wr_done,
  input logic [7:0] status,
  input logic       arr_wr_ok,
  input logic       sr_wr_ok,
  input logic       sr_launch,
  input logic       sr_abort
);

  a_r1_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[6:4] == 3'b000);

  a_r2_busy_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] == busy);

  a_r3_latch_rises_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(cs_n));

  a_r5_full_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3:2] == 2'b11) |-> !arr_wr_ok);

  a_r6_pin_lock_blocks_status: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && status[7]) |-> !sr_wr_ok);

  a_r7_bits_move_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_launch |=> ($stable(status[7]) && $stable(status[3:2])));

  a_r8_pin_drop_kills_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wp_n && status[7]) |=> !sr_launch);

  a_r8_abort_never_launches: assert property (@(posedge clk) disable iff (!rst_n)
    sr_abort |-> !sr_launch);

  a_r9_done_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !status[1]);

  a_r10_no_enable_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_done) |=> !$rose(status[1]));

endmodule

bind sguard_top sguard_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .wp_n     (wp_n),
  .busy     (busy),
  .wr_done  (wr_done),
  .status   (status),
  .arr_wr_ok(arr_wr_ok),
  .sr_wr_ok (sr_wr_ok),
  .sr_launch(sr_launch),
  .sr_abort (sr_abort)
);

// File: tb/test_sguard_top.sv
`timescale 1ns/1ps
module test_sguard_top;

  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          wren_hit = 1'b0;
  logic          wrdi_hit = 1'b0;
  logic          wrsr_hit = 1'b0;
  logic [7:0]    wrsr_byte = 8'h00;
  logic          wp_n = 1'b1;
  logic          busy = 1'b0;
  logic          wr_done = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    status;
  logic          arr_wr_ok;
  logic          sr_wr_ok;
  logic          sr_launch;

  int checks = 0;
  int errors = 0;
  logic launched;

  always #10 clk = ~clk;

  sguard_top #(.ADDR_W(AW)) i_sguard_top (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wren_hit(wren_hit), .wrdi_hit(wrdi_hit),
    .wrsr_hit(wrsr_hit), .wrsr_byte(wrsr_byte), .wp_n(wp_n), .busy(busy),
    .wr_done(wr_done), .wr_addr(wr_addr), .status(status), .arr_wr_ok(arr_wr_ok),
    .sr_wr_ok(sr_wr_ok), .sr_launch(sr_launch)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // op: 0 enable, 1 disable, 2 status write, 3 empty
  task automatic frame(input int op, input logic [7:0] d, input bit pin_drop, input bit chk_mid);
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk);
    wren_hit  = (op == 0);
    wrdi_hit  = (op == 1);
    wrsr_hit  = (op == 2);
    wrsr_byte = d;
    @(negedge clk);
    wren_hit = 1'b0; wrdi_hit = 1'b0; wrsr_hit = 1'b0;
    if (pin_drop) wp_n = 1'b0;
    #1;
    if (chk_mid && op == 0) begin
      chk("R3 latch low inside frame", status[1], 0);
      chk("R3 no array grant inside frame", arr_wr_ok, 0);
    end
    if (chk_mid && op == 1) chk("R4 latch still set before frame end", status[1], 1);
    @(negedge clk) cs_n = 1'b1;
    #1 launched = sr_launch;
    @(negedge clk);
  endtask

  task automatic cycle_done();
    @(negedge clk) busy = 1'b1;
    #1 chk("R2 busy bit follows input", status[0], 1);
    @(negedge clk) wr_done = 1'b1;
    @(negedge clk) wr_done = 1'b0; busy = 1'b0;
    #1 chk("R9 completion clears latch", status[1], 0);
  endtask

  task automatic set_status(input logic [7:0] d);
    wp_n = 1'b1;
    frame(0, 8'h00, 0, 0);
    frame(2, d, 0, 0);
    chk("R7 launch strobe on granted write", launched, 1);
    cycle_done();
  endtask

  function automatic bit locked(input int a, input int lk);
    int span;
    span = 1 << AW;
    if (lk == 0) return 0;
    if (lk == 1) return a >= (span / 4) * 3;
    if (lk == 2) return a >= span / 2;
    return 1;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset status", status, 8'h00);
    chk("R1 reset array grant", arr_wr_ok, 0);
    chk("R1 reset status grant", sr_wr_ok, 0);

    // R3: enable takes effect only at frame end
    frame(0, 8'h00, 0, 1);
    chk("R3 latch set after frame", status[1], 1);

    // R4: disable clears at frame end
    frame(1, 8'h00, 0, 1);
    chk("R4 latch cleared after frame", status[1], 0);

    // R7: masked bits never stored
    wp_n = 1'b1;
    frame(0, 8'h00, 0, 0);
    frame(2, 8'hFF, 0, 0);
    chk("R7 launch strobe", launched, 1);
    #1 chk("R7 only bits 7,3,2 stored", status, 8'h8E);
    cycle_done();
    chk("R7 status after cycle", status, 8'h8C);

    // R11: refused without latch
    frame(2, 8'h00, 0, 0);
    chk("R11 no launch without latch", launched, 0);
    chk("R11 bits kept", status, 8'h8C);

    // R8: pin drop mid-frame aborts
    frame(0, 8'h00, 0, 0);
    frame(2, 8'h00, 1, 0);
    chk("R8 no launch after pin drop", launched, 0);
    chk("R8 bits kept after abort", status, 8'h8E);
    wp_n = 1'b1;
    frame(2, 8'h84, 0, 0);
    chk("R8 launch with pin high", launched, 1);
    @(negedge clk) wp_n = 1'b0;
    @(negedge clk);
    #1 chk("R8 pin drop after launch keeps bits", status, 8'h86);
    wp_n = 1'b1;
    cycle_done();

    // R9: array write completion clears latch
    frame(0, 8'h00, 0, 0);
    chk("R9 latch set", status[1], 1);
    cycle_done();

    // R10: commands ignored while busy
    busy = 1'b1;
    frame(0, 8'h00, 0, 0);
    #1 chk("R10 enable ignored while busy", status, 8'h85);
    busy = 1'b0;
    #1 chk("R10 latch still clear", status[1], 0);
    frame(0, 8'h00, 0, 0);
    busy = 1'b1;
    frame(2, 8'h00, 0, 0);
    chk("R10 status write ignored while busy", launched, 0);
    frame(1, 8'h00, 0, 0);
    busy = 1'b0;
    #1 chk("R10 bits and latch kept", status, 8'h86);
    cycle_done();

    // R5, R6, R2 sweep
    for (int lk = 0; lk < 4; lk++) begin
      for (int le = 0; le < 2; le++) begin
        set_status({le[0], 3'b000, lk[1:0], 2'b00});
        for (int w = 0; w < 2; w++) begin
          if (w == 1) frame(0, 8'h00, 0, 0);
          else        frame(1, 8'h00, 0, 0);
          chk("R1 status layout", status, {le[0], 3'b000, lk[1:0], w[0], 1'b0});
          for (int p = 0; p < 2; p++) begin
            for (int b = 0; b < 2; b++) begin
              wp_n = p[0];
              busy = b[0];
              #1;
              chk("R2 busy bit", status[0], b);
              chk("R6 status grant", sr_wr_ok, (w == 1) && (b == 0) && !((le == 1) && (p == 0)));
              for (int a = 0; a < 64; a++) begin
                wr_addr = AW'((a * 256) + a * 3);
                #1 chk("R5 array grant", arr_wr_ok,
                       (w == 1) && (b == 0) && !locked((a * 256) + a * 3, lk));
              end
              for (int e = 0; e < 2; e++) begin
                wr_addr = (e == 0) ? AW'(12287) : AW'(8191);
                #1 chk("R5 range edge", arr_wr_ok,
                       (w == 1) && (b == 0) && !locked(int'(wr_addr), lk));
              end
            end
          end
          wp_n = 1'b1;
          busy = 1'b0;
        end
        frame(1, 8'h00, 0, 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule